// File: doc/BRIEF.md
# Interleaved Multi-Bank Access Scheduler

This block sits in front of a four-bank DRAM and issues single-byte accesses in the order they arrive. Each request carries a 22-bit byte address. A parameter picks one of two bank selection schemes:

- **Interleaved:** the bank number comes from the lowest address bits.
- **Linear:** the bank number comes from the highest address bits.

Once the address is split into bank, row and column, the block issues one command per request. It holds back any request that would hit a bank that is still precharging.

An access occupies the shared array path for the row time plus the column time. When the access ends, its bank closes the row and precharges for a fixed number of cycles. An access to another bank that has already precharged may start at once, so that bank's precharge overlaps useful work. When the next request targets a bank whose precharge has not finished, it waits, and the precharge time shows up in the total.

A free-running cycle counter is brought out so that total sweep times can be compared against the figures expected for each mapping. Typical figures use 20 ns each for row, column and precharge.

Top module: `bank_interleave_sched`

## Requirements
- R1: With `MAP_MODE` = `MAP_LOW`, the address splits as follows: bits 1:0 give the bank, bits 11:2 give the column and bits 21:12 give the row. For example, 0x3A5A2E maps to bank 2, row 0x3A5 and column 0x28B.
- R2: With `MAP_MODE` = `MAP_HIGH`, the address splits as follows: bits 21:20 give the bank, bits 19:10 give the row and bits 9:0 give the column. For example, 0x3A5A2E maps to bank 3, row 0x296 and column 0x22E.
- R3: Reset leaves every bank precharging for `T_PRE` cycles. During the first `T_PRE` cycles after reset, `req_ready` is low, `cmd_valid` is low and `elapsed` starts at 0.
- R4: A request is accepted in a cycle when three conditions hold: `req_valid` is high, no access is in progress, and the target bank has finished precharging. In the cycle after acceptance, `cmd_valid` pulses for one cycle with that request's bank, row and column. No command appears without an accepted request.
- R5: An access holds the array for T_ACC = `T_ROW` + `T_COL` cycles, counting the accept cycle. A following request to a different, already precharged bank is accepted exactly T_ACC cycles after the previous acceptance.
- R6: When an access ends, its bank precharges for `T_PRE` cycles. A request to that same bank is accepted no earlier than T_ACC + `T_PRE` cycles after the previous acceptance in that bank.
- R7: `req_stall` is high exactly in the cycles where `req_valid` is high and the request is not accepted.
- R8: Requests are served strictly in arrival order. Each accepted request produces exactly one command.
- R9: `elapsed` increments by one every cycle after reset is released.
- R10: Take a sweep of 1000 sequential addresses starting at 500, presented from the first cycle after reset. The last access ends after `T_PRE` + 1000·T_ACC cycles with low-order mapping, and after 1000·(T_ACC + `T_PRE`) cycles with high-order mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 22 | Byte address of the request |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| req_stall | output | 1 | Request present but held back |
| cmd_valid | output | 1 | One-cycle pulse: command issued |
| cmd_bank | output | 2 | Bank of the issued command |
| cmd_row | output | 10 | Row of the issued command |
| cmd_col | output | 10 | Column of the issued command |
| elapsed | output | 32 | Cycles since reset release |

## Verification
The assertions assume a handshake in which the block alone decides acceptance. They also assume that `req_addr` is meaningful only while `req_valid` is high, and that `T_ROW` and `T_COL` are each at least one cycle, so two commands can never be adjacent. The stimulus changes `req_addr` and `req_valid` only on the falling edge, and only after seeing whether the previous request was accepted. Every timed sequence starts directly from reset with the request already presented, so the bench's own per-bank ready-time model and the design share one time base.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int BANK_W = 2;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 10;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic { MAP_LOW = 1'b0, MAP_HIGH = 1'b1 } map_mode_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } dram_loc_t;

  // bank in the least significant bits, column next, row on top
  function automatic dram_loc_t map_low(input logic [ADDR_W-1:0] a);
    dram_loc_t l;
    l.bank = a[BANK_W-1:0];
    l.col  = a[BANK_W +: COL_W];
    l.row  = a[BANK_W+COL_W +: ROW_W];
    return l;
  endfunction

  // column in the least significant bits, row next, bank on top
  function automatic dram_loc_t map_high(input logic [ADDR_W-1:0] a);
    dram_loc_t l;
    l.col  = a[COL_W-1:0];
    l.row  = a[COL_W +: ROW_W];
    l.bank = a[COL_W+ROW_W +: BANK_W];
    return l;
  endfunction

endpackage

// File: rtl/sched_addr_map.sv
module sched_addr_map
  import sched_pkg::*;
#(
  parameter map_mode_e MODE = MAP_LOW
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dram_loc_t         loc_o
);

  generate
    if (MODE == MAP_HIGH) begin : g_high
      always_comb loc_o = map_high(addr_i);
    end else begin : g_low
      always_comb loc_o = map_low(addr_i);
    end
  endgenerate

endmodule

// File: rtl/sched_bank_timer.sv
module sched_bank_timer #(
  parameter int T_PRE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic close_i,   // this bank's access ends this cycle
  input  logic issue_i,   // an access to this bank is accepted this cycle
  output logic ready_o
);

  localparam int PRE_W = $clog2(T_PRE + 2);

  logic [PRE_W-1:0] pre_cnt;

  // reset counts as a precharge in progress for every bank
  always_ff @(posedge clk) begin
    if (!rst_n)            pre_cnt <= PRE_W'(T_PRE);
    else if (close_i)      pre_cnt <= PRE_W'(T_PRE);
    else if (pre_cnt != 0) pre_cnt <= pre_cnt - 1'b1;
  end

  assign ready_o = (pre_cnt == '0);

  // R6: no access may be accepted while this bank precharges
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !issue_i);

  // R6: a bank was idle when its access began, so it is still idle when it closes
  p_close_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |-> ready_o);

endmodule

// File: rtl/sched_access_seq.sv
module sched_access_seq
  import sched_pkg::*;
#(
  parameter int T_ACC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  dram_loc_t         loc_i,
  output logic              busy_o,
  output logic              close_o,
  output logic [BANK_W-1:0] close_bank_o,
  output logic              cmd_valid_o,
  output dram_loc_t         cmd_loc_o
);

  localparam int ACC_W = $clog2(T_ACC + 1);

  logic [ACC_W-1:0]  acc_cnt;
  logic [BANK_W-1:0] act_bank;

  // the accept cycle is the first of T_ACC occupied cycles
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      act_bank <= '0;
    end else if (issue_i) begin
      acc_cnt  <= ACC_W'(T_ACC - 1);
      act_bank <= loc_i.bank;
    end else if (acc_cnt != 0) begin
      acc_cnt  <= acc_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_loc_o   <= '0;
    end else begin
      cmd_valid_o <= issue_i;
      if (issue_i) cmd_loc_o <= loc_i;
    end
  end

  assign busy_o       = (acc_cnt != 0);
  assign close_o      = (acc_cnt == ACC_W'(1));
  assign close_bank_o = act_bank;

  // R5: the array path serves one access at a time
  p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !issue_i);

  // R5: accesses last at least two cycles, so commands never touch
  p_cmd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

endmodule

// File: rtl/bank_interleave_sched.sv
module bank_interleave_sched
  import sched_pkg::*;
#(
  parameter map_mode_e MAP_MODE = MAP_LOW,
  parameter int        T_ROW    = 2,
  parameter int        T_COL    = 2,
  parameter int        T_PRE    = 2,
  parameter int        CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_stall,
  output logic              cmd_valid,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [CNT_W-1:0]  elapsed
);

  localparam int T_ACC = T_ROW + T_COL;

  // named internal events
  dram_loc_t              req_loc;
  dram_loc_t              cmd_loc;
  logic                   acc_busy;
  logic                   acc_close;
  logic [BANK_W-1:0]      close_bank;
  logic [NUM_BANKS-1:0]   bank_ready;
  logic                   issue;

  sched_addr_map #(.MODE(MAP_MODE)) u_map (
    .addr_i (req_addr),
    .loc_o  (req_loc)
  );

  sched_access_seq #(.T_ACC(T_ACC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue),
    .loc_i        (req_loc),
    .busy_o       (acc_busy),
    .close_o      (acc_close),
    .close_bank_o (close_bank),
    .cmd_valid_o  (cmd_valid),
    .cmd_loc_o    (cmd_loc)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sched_bank_timer #(.T_PRE(T_PRE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .close_i (acc_close && (close_bank == BANK_W'(b))),
        .issue_i (issue && (req_loc.bank == BANK_W'(b))),
        .ready_o (bank_ready[b])
      );
    end
  endgenerate

  assign req_ready = !acc_busy && bank_ready[req_loc.bank];
  assign issue     = req_valid && req_ready;
  assign req_stall = req_valid && !req_ready;

  assign cmd_bank = cmd_loc.bank;
  assign cmd_row  = cmd_loc.row;
  assign cmd_col  = cmd_loc.col;

  always_ff @(posedge clk) begin
    if (!rst_n) elapsed <= '0;
    else        elapsed <= elapsed + CNT_W'(1);
  end

  // R7: a held-back request produces no command in the next cycle
  p_stall_no_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |=> !cmd_valid);

  // R9: the cycle counter advances by exactly one per cycle
  p_elapsed_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (elapsed == $past(elapsed) + CNT_W'(1)));

  // R4: every command comes from a request accepted one cycle earlier
  p_cmd_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(req_valid));

  generate
    if (MAP_MODE == MAP_HIGH) begin : g_chk_high
      // R2: command fields reassemble into the accepted address
      p_map_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({cmd_bank, cmd_row, cmd_col} == $past(req_addr)));
    end else begin : g_chk_low
      // R1: command fields reassemble into the accepted address
      p_map_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({cmd_row, cmd_col, cmd_bank} == $past(req_addr)));
    end
  endgenerate

endmodule

// File: tb/tb_bank_interleave_sched.sv
module tb_bank_interleave_sched;
  import sched_pkg::*;

  localparam int T_ROW = 2;
  localparam int T_COL = 2;
  localparam int T_PRE = 2;
  localparam int T_ACC = T_ROW + T_COL;

  // addr, low bank/row/col, high bank/row/col (worked out by hand)
  localparam int NV = 7;
  localparam logic [65:0] VEC [NV] = '{
    {22'h000000, 2'd0, 10'h000, 10'h000, 2'd0, 10'h000, 10'h000},
    {22'h3FFFFF, 2'd3, 10'h3FF, 10'h3FF, 2'd3, 10'h3FF, 10'h3FF},
    {22'h3A5A2E, 2'd2, 10'h3A5, 10'h28B, 2'd3, 10'h296, 10'h22E},
    {22'h3A5A2F, 2'd3, 10'h3A5, 10'h28B, 2'd3, 10'h296, 10'h22F},
    {22'h3A5A30, 2'd0, 10'h3A5, 10'h28C, 2'd3, 10'h296, 10'h230},
    {22'h0001F4, 2'd0, 10'h000, 10'h07D, 2'd0, 10'h000, 10'h1F4},
    {22'h100C07, 2'd3, 10'h100, 10'h301, 2'd1, 10'h003, 10'h007}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_v = 1'b0;
  logic [21:0] req_a = '0;
  logic use_hi = 1'b0;

  logic rdy_lo, stall_lo, cv_lo, rdy_hi, stall_hi, cv_hi;
  logic [1:0] bk_lo, bk_hi;
  logic [9:0] rw_lo, rw_hi, cl_lo, cl_hi;
  logic [31:0] el_lo, el_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_interleave_sched #(.MAP_MODE(MAP_LOW), .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v && !use_hi), .req_addr(req_a),
    .req_ready(rdy_lo), .req_stall(stall_lo), .cmd_valid(cv_lo),
    .cmd_bank(bk_lo), .cmd_row(rw_lo), .cmd_col(cl_lo), .elapsed(el_lo));

  bank_interleave_sched #(.MAP_MODE(MAP_HIGH), .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE)) dut_hi (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v && use_hi), .req_addr(req_a),
    .req_ready(rdy_hi), .req_stall(stall_hi), .cmd_valid(cv_hi),
    .cmd_bank(bk_hi), .cmd_row(rw_hi), .cmd_col(cl_hi), .elapsed(el_hi));

  wire        rdy   = use_hi ? rdy_hi   : rdy_lo;
  wire        stall = use_hi ? stall_hi : stall_lo;
  wire        cv    = use_hi ? cv_hi    : cv_lo;
  wire [1:0]  bk    = use_hi ? bk_hi    : bk_lo;
  wire [9:0]  rw    = use_hi ? rw_hi    : rw_lo;
  wire [9:0]  cl    = use_hi ? cl_hi    : cl_lo;
  wire [31:0] el    = use_hi ? el_hi    : el_lo;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_bank(input logic [21:0] a);
    return use_hi ? a[21:20] : a[1:0];
  endfunction
  function automatic logic [9:0] exp_row(input logic [21:0] a);
    return use_hi ? a[19:10] : a[21:12];
  endfunction
  function automatic logic [9:0] exp_col(input logic [21:0] a);
    return use_hi ? a[9:0] : a[11:2];
  endfunction

  task automatic do_reset();
    req_v = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Presents base + i*stride for i < n, starting in cycle 0 after reset,
  // and checks every command against a per-bank ready-time model.
  task automatic run_stream(input logic [21:0] base, input int stride, input int n,
                            output longint last_el);
    longint t_free = 0;
    longint brdy [4];
    longint iss;
    int i = 0;
    logic [21:0] a = base;
    logic [1:0] b;
    bit acc;
    for (int k = 0; k < 4; k++) brdy[k] = T_PRE;
    last_el = -1;
    req_a = a;
    req_v = 1'b1;
    while (i < n) begin
      #1;
      acc = rdy;
      chk("R7 stall", stall, !acc);
      @(negedge clk);
      if (acc) begin
        b = exp_bank(a);
        iss = (t_free > brdy[b]) ? t_free : brdy[b];
        chk("R4 cmd pulse", cv, 1);
        chk("R5 R6 cmd cycle", el, iss + 1);
        chk(use_hi ? "R2 R8 bank" : "R1 R8 bank", bk, b);
        chk(use_hi ? "R2 R8 row" : "R1 R8 row", rw, exp_row(a));
        chk(use_hi ? "R2 R8 col" : "R1 R8 col", cl, exp_col(a));
        t_free = iss + T_ACC;
        brdy[b] = iss + T_ACC + T_PRE;
        last_el = el;
        i++;
        if (i < n) begin
          a = base + 22'(i * stride);
          req_a = a;
        end else begin
          req_v = 1'b0;
        end
      end else begin
        chk("R4 no cmd while held", cv, 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    longint le;
    longint first_el;

    // table of mapping vectors, each issued to both mappings
    for (int v = 0; v < NV; v++) begin
      use_hi = 1'b0;
      do_reset();
      run_stream(VEC[v][65:44], 1, 1, le);
      chk("R1 table bank", bk, VEC[v][43:42]);
      chk("R1 table row", rw, VEC[v][41:32]);
      chk("R1 table col", cl, VEC[v][31:22]);
      chk("R3 first cmd cycle", le, T_PRE + 1);
      use_hi = 1'b1;
      do_reset();
      run_stream(VEC[v][65:44], 1, 1, le);
      chk("R2 table bank", bk, VEC[v][21:20]);
      chk("R2 table row", rw, VEC[v][19:10]);
      chk("R2 table col", cl, VEC[v][9:0]);
    end

    // R3 reset state, R9 counter start
    use_hi = 1'b0;
    do_reset();
    req_a = 22'h000001;
    req_v = 1'b1;
    #1;
    chk("R3 ready after reset", rdy, 0);
    chk("R3 cmd after reset", cv, 0);
    chk("R9 elapsed at start", el, 0);
    chk("R7 stall after reset", stall, 1);
    @(negedge clk); #1;
    chk("R3 ready cycle 1", rdy, 0);
    chk("R9 elapsed cycle 1", el, 1);
    @(negedge clk); #1;
    chk("R3 ready once precharged", rdy, 1);
    chk("R9 elapsed cycle 2", el, 2);
    req_v = 1'b0;
    #1;
    chk("R7 no stall without request", stall, 0);
    @(negedge clk); #1;
    chk("R4 no request no cmd", cv, 0);

    // R5 rotation through banks, precharge hidden
    use_hi = 1'b0;
    do_reset();
    run_stream(22'h3A5A2E, 1, 3, le);
    chk("R5 three banks end", le, T_PRE + 2 * T_ACC + 1);

    // R6 same bank repeated under low mapping
    do_reset();
    run_stream(22'h000000, 4, 3, le);
    chk("R6 same bank end", le, T_PRE + 2 * (T_ACC + T_PRE) + 1);

    // R6 sequential addresses share a bank under high mapping
    use_hi = 1'b1;
    do_reset();
    run_stream(22'h3A5A2E, 1, 3, le);
    chk("R6 high same bank end", le, T_PRE + 2 * (T_ACC + T_PRE) + 1);

    // R10 sweeps of 1000 bytes from address 500
    use_hi = 1'b0;
    do_reset();
    run_stream(22'd500, 1, 1000, le);
    chk("R10 low sweep total", le + T_ACC - 1, T_PRE + 1000 * T_ACC);

    use_hi = 1'b1;
    do_reset();
    run_stream(22'd500, 1, 1000, le);
    chk("R10 high sweep total", le + T_ACC - 1, 1000 * (T_ACC + T_PRE));

    first_el = el;
    @(negedge clk);
    chk("R9 free running", el, first_el + 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule